// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block keeps wall-clock time and calendar date in eight 8-bit BCD registers. It advances on a single-cycle 100 Hz tick enable that a divider elsewhere supplies. The registers hold hundredths, seconds, minutes, hours, day of week, date, month and two-digit year. Month lengths are built in, and February gets 29 days in years divisible by four. The hours register can run in a 24-hour format or in a 12-hour format with a PM flag.

A serial access controller sits next to this block. It writes all eight registers at once through a 64-bit parallel load port, and it reads a snapshot of all eight through the 64-bit readback port. The day register also holds two control bits. One stops all counting. The other decides whether an external active-low reset pin may raise a transfer-abort request to that controller.

Top module: `rtc_calendar`

## Requirements
- R1: Hundredths count 00 to 99 in BCD and then carry into seconds. Seconds and minutes count 00 to 59 and then carry onward.
- R2: With hours bit 7 at 0 (24-hour format), hours run 00 to 23 and bit 5 is the twenty digit. Stepping past 23:59:59.99 gives 00:00:00.00 and advances the day and the date.
- R3: With hours bit 7 at 1 (12-hour format), bit 5 is PM (1 = PM) and bits 4:0 hold 01 to 12. The step from 11 goes to 12 and toggles PM, and the step from 12 goes to 01. Stepping past 11:59:59.99 PM advances the date.
- R4: Day of week (register 4, bits 2:0) runs 1 to 7 and wraps to 1.
- R5: The date rolls to 01 and the month advances after day 30 of April, June, September and November, and after day 31 of the other months except February.
- R6: February ends after 29 when the BCD year is divisible by 4 and after 28 otherwise. Month 12 wraps to 01 with a year carry, and year 99 wraps to 00.
- R7: While register 4 bit 5 is 1, ticks change no register.
- R8: A load replaces all eight registers in one cycle. A tick in the same cycle as the load is dropped.
- R9: Bits with no use read as 0 whatever was loaded. These are bit 7 of seconds and minutes, bit 6 of hours, bits 7:6 and 3 of day, bits 7:6 of date, and bits 7:5 of month.
- R10: The abort request is high exactly while the external reset input is low and register 4 bit 4 is 0. When that bit is 1, the reset input is ignored.
- R11: Readback byte i is register i, in this order: 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. After reset the registers hold 00:00:00.00 in 24-hour format, day 1, date 01, month 01, year 00, running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 100 Hz advance enable |
| load_en | input | 1 | Parallel load strobe |
| load_data | input | 64 | Values to load, byte i to register i |
| ext_rst_n | input | 1 | External active-low reset pin |
| snap_data | output | 64 | Readback of all registers, byte i is register i |
| xfer_abort | output | 1 | Request to abort a serial transfer |

## Verification
The hardest states to reach from the ports are the deep carry chains. Examples are the last hundredth of the last day of a month, of a leap or non-leap February, and of year 99. Reaching them by ticking would take billions of cycles. Each test instead loads a state one hundredth before the boundary through the parallel port and then sends a single tick. The 12-hour midnight crossing and the tick dropped during a load are set up the same way.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int NREG = 8;
    localparam int RW   = 8;
    localparam int BUSW = NREG * RW;

    localparam int IX_HUND = 0;
    localparam int IX_SEC  = 1;
    localparam int IX_MIN  = 2;
    localparam int IX_HOUR = 3;
    localparam int IX_DAY  = 4;
    localparam int IX_DATE = 5;
    localparam int IX_MON  = 6;
    localparam int IX_YEAR = 7;

    localparam int DAY_HALT_BIT = 5;
    localparam int DAY_RIGN_BIT = 4;

    // bits that exist in each register
    localparam logic [BUSW-1:0] KEEP_MASK = 64'hFF1F_3F37_BF7F_7FFF;

    typedef logic [RW-1:0] reg_t;

    typedef struct packed {
        reg_t year;
        reg_t mon;
        reg_t date;
        reg_t day;
        reg_t hour;
        reg_t min;
        reg_t sec;
        reg_t hund;
    } cal_t;

    function automatic reg_t bcd_inc(input reg_t v);
        reg_t r;
        if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction
endpackage

// File: rtl/rtc_month_days.sv
module rtc_month_days
    import rtc_pkg::*;
(
    input  reg_t mon,
    input  reg_t year,
    output reg_t last_date
);
    logic [6:0] ybin;
    logic       leap;

    always_comb begin
        ybin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
        leap = (ybin[1:0] == 2'b00);
        case (mon[4:0])
            5'h02:                      last_date = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_hour_next.sv
module rtc_hour_next
    import rtc_pkg::*;
(
    input  reg_t hour,
    output reg_t hour_nx,
    output logic day_wrap
);
    always_comb begin
        hour_nx  = hour;
        day_wrap = 1'b0;
        if (!hour[7]) begin
            if (hour[5:0] == 6'h23) begin
                hour_nx  = 8'h00;
                day_wrap = 1'b1;
            end else if (hour[3:0] == 4'd9) begin
                hour_nx[3:0] = 4'd0;
                if (hour[5:4] == 2'b00) hour_nx[5:4] = 2'b01;
                else                    hour_nx[5:4] = 2'b10;
            end else begin
                hour_nx[3:0] = hour[3:0] + 4'd1;
            end
        end else begin
            if (hour[4:0] == 5'h12) begin
                hour_nx[4:0] = 5'h01;
            end else if (hour[4:0] == 5'h11) begin
                hour_nx[4:0] = 5'h12;
                hour_nx[5]   = ~hour[5];
                day_wrap     = hour[5];
            end else if (hour[3:0] == 4'd9) begin
                hour_nx[4:0] = 5'h10;
            end else begin
                hour_nx[3:0] = hour[3:0] + 4'd1;
            end
        end
    end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load_en,
    input  logic [BUSW-1:0] load_data,
    input  logic            ext_rst_n,
    output logic [BUSW-1:0] snap_data,
    output logic            xfer_abort
);
    localparam cal_t RESET_VAL = '{year: 8'h00, mon: 8'h01, date: 8'h01,
                                   day: 8'h01, hour: 8'h00, min: 8'h00,
                                   sec: 8'h00, hund: 8'h00};

    cal_t cal_q, cal_d;
    reg_t last_date, hour_nx;
    logic hour_wrap;

    rtc_month_days u_mdays (.mon(cal_q.mon), .year(cal_q.year), .last_date(last_date));
    rtc_hour_next  u_hnext (.hour(cal_q.hour), .hour_nx(hour_nx), .day_wrap(hour_wrap));

    always_comb begin
        logic adv, c_sec, c_min, c_hour, c_day, c_mon, c_year;
        cal_d  = cal_q;
        adv    = tick && !cal_q.day[DAY_HALT_BIT] && !load_en;
        c_sec  = adv    && (cal_q.hund == 8'h99);
        c_min  = c_sec  && (cal_q.sec  == 8'h59);
        c_hour = c_min  && (cal_q.min  == 8'h59);
        c_day  = c_hour && hour_wrap;
        c_mon  = c_day  && (cal_q.date[5:0] == last_date[5:0]);
        c_year = c_mon  && (cal_q.mon[4:0] == 5'h12);

        if (load_en) begin
            cal_d = cal_t'(load_data & KEEP_MASK);
        end else begin
            if (adv)    cal_d.hund = c_sec ? 8'h00 : bcd_inc(cal_q.hund);
            if (c_sec)  cal_d.sec  = c_min ? 8'h00 : bcd_inc(cal_q.sec);
            if (c_min)  cal_d.min  = c_hour ? 8'h00 : bcd_inc(cal_q.min);
            if (c_hour) cal_d.hour = hour_nx;
            if (c_day) begin
                cal_d.day[2:0] = (cal_q.day[2:0] == 3'd7) ? 3'd1 : cal_q.day[2:0] + 3'd1;
                cal_d.date     = c_mon ? 8'h01 : bcd_inc(cal_q.date);
            end
            if (c_mon)  cal_d.mon  = c_year ? 8'h01 : bcd_inc(cal_q.mon);
            if (c_year) cal_d.year = (cal_q.year == 8'h99) ? 8'h00 : bcd_inc(cal_q.year);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= RESET_VAL;
        else        cal_q <= cal_d;
    end

    assign snap_data  = cal_q;
    assign xfer_abort = !ext_rst_n && !cal_q.day[DAY_RIGN_BIT];
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            load_en,
    input logic [BUSW-1:0] load_data,
    input logic            ext_rst_n,
    input logic [BUSW-1:0] snap_data,
    input logic            xfer_abort
);
    AST_LOAD_APPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> snap_data == ($past(load_data) & KEEP_MASK)); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_en) |=> $stable(snap_data)); // R1
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && snap_data[8*IX_DAY+DAY_HALT_BIT]) |=> $stable(snap_data)); // R7
    AST_HUND_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en && !snap_data[8*IX_DAY+DAY_HALT_BIT])
        |=> snap_data[7:0] != $past(snap_data[7:0])); // R1
    AST_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_data & ~KEEP_MASK) == '0); // R9
    AST_ABORT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_abort |-> !ext_rst_n); // R10
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
    .load_data(load_data), .ext_rst_n(ext_rst_n),
    .snap_data(snap_data), .xfer_abort(xfer_abort)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        load_en = 1'b0;
    logic [63:0] load_data = '0;
    logic        ext_rst_n = 1'b1;
    logic [63:0] snap_data;
    logic        xfer_abort;
    int          n_run = 0;
    int          n_fail = 0;

    rtc_calendar u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .load_en(load_en),
                     .load_data(load_data), .ext_rst_n(ext_rst_n),
                     .snap_data(snap_data), .xfer_abort(xfer_abort));

    always #5 clk = ~clk;

    function automatic logic [63:0] pk(input logic [7:0] yr, mo, dt, dw, hr, mi, se, hu);
        return {yr, mo, dt, dw, hr, mi, se, hu};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [63:0] v, input logic with_tick);
        @(negedge clk);
        load_en = 1'b1; load_data = v; tick = with_tick;
        @(negedge clk);
        load_en = 1'b0; tick = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic step_check(input string req, input logic [63:0] start, exp);
        do_load(start, 1'b0);
        do_ticks(1);
        chk(req, snap_data, exp);
    endtask

    task automatic t_reset;
        chk("R11 reset", snap_data, pk(8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_r1;
        step_check("R1 sec/min carry", pk(8'h23, 8'h06, 8'h15, 8'h03, 8'h08, 8'h00, 8'h59, 8'h99),
                   pk(8'h23, 8'h06, 8'h15, 8'h03, 8'h08, 8'h01, 8'h00, 8'h00));
        step_check("R1 units carry", pk(8'h23, 8'h06, 8'h15, 8'h03, 8'h08, 8'h14, 8'h29, 8'h49),
                   pk(8'h23, 8'h06, 8'h15, 8'h03, 8'h08, 8'h14, 8'h29, 8'h50));
    endtask

    task automatic t_r2_r4;
        step_check("R2 R4 midnight 24h", pk(8'h24, 8'h03, 8'h10, 8'h07, 8'h23, 8'h59, 8'h59, 8'h99),
                   pk(8'h24, 8'h03, 8'h11, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00));
        step_check("R2 into twenties", pk(8'h24, 8'h03, 8'h10, 8'h02, 8'h19, 8'h59, 8'h59, 8'h99),
                   pk(8'h24, 8'h03, 8'h10, 8'h02, 8'h20, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_r3;
        step_check("R3 11AM to 12PM", pk(8'h24, 8'h05, 8'h05, 8'h02, 8'h91, 8'h59, 8'h59, 8'h99),
                   pk(8'h24, 8'h05, 8'h05, 8'h02, 8'hB2, 8'h00, 8'h00, 8'h00));
        step_check("R3 11PM to 12AM", pk(8'h24, 8'h05, 8'h05, 8'h02, 8'hB1, 8'h59, 8'h59, 8'h99),
                   pk(8'h24, 8'h05, 8'h06, 8'h03, 8'h92, 8'h00, 8'h00, 8'h00));
        step_check("R3 12 to 01", pk(8'h24, 8'h05, 8'h06, 8'h03, 8'h92, 8'h59, 8'h59, 8'h99),
                   pk(8'h24, 8'h05, 8'h06, 8'h03, 8'h81, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_r5;
        step_check("R5 Apr 30", pk(8'h21, 8'h04, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59, 8'h99),
                   pk(8'h21, 8'h05, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00));
        step_check("R5 Jan 30", pk(8'h21, 8'h01, 8'h30, 8'h04, 8'h23, 8'h59, 8'h59, 8'h99),
                   pk(8'h21, 8'h01, 8'h31, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_r6;
        step_check("R6 Feb 28 leap", pk(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                   pk(8'h24, 8'h02, 8'h29, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_check("R6 Feb 28 plain", pk(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                   pk(8'h23, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_check("R6 Feb 29 leap", pk(8'h16, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59, 8'h99),
                   pk(8'h16, 8'h03, 8'h01, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00));
        step_check("R6 year 99 wrap", pk(8'h99, 8'h12, 8'h31, 8'h06, 8'h23, 8'h59, 8'h59, 8'h99),
                   pk(8'h00, 8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    task automatic t_r7;
        logic [63:0] v;
        v = pk(8'h22, 8'h07, 8'h04, 8'h21, 8'h10, 8'h20, 8'h30, 8'h40);
        do_load(v, 1'b0);
        do_ticks(5);
        chk("R7 halted", snap_data, v);
    endtask

    task automatic t_r8;
        logic [63:0] v;
        v = pk(8'h22, 8'h07, 8'h04, 8'h01, 8'h10, 8'h20, 8'h30, 8'h40);
        do_load(v, 1'b1);
        chk("R8 tick dropped", snap_data, v);
        do_ticks(1);
        chk("R8 next tick counts", snap_data, pk(8'h22, 8'h07, 8'h04, 8'h01, 8'h10, 8'h20, 8'h30, 8'h41));
    endtask

    task automatic t_r9;
        do_load(pk(8'h45, 8'hE5, 8'hC7, 8'hC9, 8'h45, 8'hB3, 8'h92, 8'h12), 1'b0);
        chk("R9 zero bits", snap_data, pk(8'h45, 8'h05, 8'h07, 8'h01, 8'h05, 8'h33, 8'h12, 8'h12));
    endtask

    task automatic t_r10;
        do_load(pk(8'h20, 8'h01, 8'h01, 8'h21, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        @(negedge clk); ext_rst_n = 1'b0; #1;
        chk("R10 abort enabled", {63'd0, xfer_abort}, 64'd1);
        do_load(pk(8'h20, 8'h01, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R10 reset ignored", {63'd0, xfer_abort}, 64'd0);
        @(negedge clk); ext_rst_n = 1'b1; #1;
        chk("R10 pin high", {63'd0, xfer_abort}, 64'd0);
        chk("R10 time kept", snap_data, pk(8'h20, 8'h01, 8'h01, 8'h31, 8'h00, 8'h00, 8'h00, 8'h00));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_r1();
        t_r2_r4();
        t_r3();
        t_r5();
        t_r6();
        t_r7();
        t_r8();
        t_r9();
        t_r10();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule